// File: doc/BRIEF.md
# Quad serial thermometer interface

This block sits on a simple register bus and stands in for four three-wire serial temperature sensors that share one command stream. Software moves the sensor lines by hand, one bit per bus write. A control register takes a reset code, a clock-low code and a clock-high code. A data-write register takes one command or data bit per write.

A command is eight bits, sent least significant bit first. When it is a read command, each read of the data-read register returns one bit position from all four sensors at once. Bit i of the returned word belongs to sensor i. Each sensor has a 9-bit temperature register and an 8-bit configuration register. Both are loaded at reset and fixed after that. No conversion is modelled.

The transfer state resets itself at the end of a read transfer, and also when a start-conversion command is received. A read that arrives while no read command is active returns zero and raises a sticky flag.

Top module: `quad_thermo_if`

## Requirements
- R1: After rst_n is released, rdata is 0, unk_cmd is 0 and the clock-low flag is clear. With the flag clear, command bits written before any clock-low code are ignored.
- R2: Address map: 0 is control, 1 is data write, 2 is data read. The control codes are 0x01 (transfer reset), 0x02 (clock low) and 0x03 (clock high).
- R3: A data write is ignored unless the clock-low flag is set. The enable-read code 0x80 is the one exception.
- R4: Command bits are shifted in least significant bit first, eight of them. A bit counts as 1 only when the written value is exactly 0x01; any other value, 0x05 for example, counts as 0.
- R5: Command 0xAA selects read-temperature. Nine reads return temperature bits 0 to 8, each replicated across the four lanes; the reset value is 44. After the ninth read the transfer state is cleared.
- R6: Command 0xAC selects read-configuration. Eight reads return configuration bits 0 to 7; the reset value is 0x02. After the eighth read the transfer state is cleared.
- R7: Command 0xEE (start conversion) clears the transfer state as soon as its eighth bit arrives. The next eight qualified bits then form a new command.
- R8: A data write of 0x80 resets only the data bit position, whatever the clock-low flag. The active command is kept.
- R9: Writing control code 0x01 clears the command, the command position, the data word and the data position. The clock-low flag is left as it was.
- R10: A data read with no completed read command returns 0 and sets unk_cmd. unk_cmd then stays set until rst_n.
- R11: rdata changes only on a data read and holds its value across all other bus activity.
- R12: Once a command is complete, qualified data writes go into the data word and advance the data position. The command itself is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | NSENS | Registered read data, one bit per sensor |
| unk_cmd | output | 1 | Sticky flag: a read was made with no valid read command |

## Verification
The bench builds the block with its default parameters: four sensors, an 8-bit command, 8-bit configuration and 9-bit temperature transfers, and a 16-bit data word. With these values, full transfers of both lengths are short enough to walk through completely. The bench reads past the end of each transfer, aborts transfers halfway, and restarts a transfer with the enable-read code. The order of the table is arranged so that the first unknown-command read is the one that follows an automatic end of transfer. That makes the sticky flag show whether the automatic reset fired.

// File: rtl/quad_thermo_if.sv
module quad_thermo_if #(
  parameter int NSENS      = 4,
  parameter int CMD_LEN    = 8,
  parameter int CFG_LEN    = 8,
  parameter int TMP_LEN    = 9,
  parameter int DWORD_W    = 16,
  parameter int TEMP_INIT  = 44,
  parameter int CFG_INIT   = 'h02,
  parameter int OP_RDTEMP  = 'hAA,
  parameter int OP_RDCFG   = 'hAC,
  parameter int OP_CONV    = 'hEE,
  parameter logic [7:0] C_RST   = 8'h01,
  parameter logic [7:0] C_CLKLO = 8'h02,
  parameter logic [7:0] C_CLKHI = 8'h03,
  parameter logic [7:0] D_HIGH  = 8'h01,
  parameter logic [7:0] D_ENRD  = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [NSENS-1:0] rdata,
  output logic             unk_cmd
);

  localparam int CPW = $clog2(CMD_LEN + 1);
  localparam int CIW = (CMD_LEN > 1) ? $clog2(CMD_LEN) : 1;
  localparam int DPW = $clog2(DWORD_W + 1);
  localparam int DIW = (DWORD_W > 1) ? $clog2(DWORD_W) : 1;
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_DWR = 2'd1;
  localparam logic [1:0] A_DRD = 2'd2;

  logic               clk_low;
  logic [CMD_LEN-1:0] cmd;
  logic [CPW-1:0]     cmd_pos;
  logic [DWORD_W-1:0] dword;
  logic [DPW-1:0]     dpos;
  logic [TMP_LEN-1:0] temp_r [NSENS];
  logic [CFG_LEN-1:0] cfg_r  [NSENS];
  logic [NSENS-1:0]   sel_bits;

  wire wr_ctl = wr_en && addr == A_CTL;
  wire wr_dat = wr_en && addr == A_DWR;
  wire rd_dat = rd_en && !wr_en && addr == A_DRD;

  wire cmd_done = cmd_pos == CPW'(CMD_LEN);
  wire is_temp  = cmd == CMD_LEN'(OP_RDTEMP);
  wire is_cfg   = cmd == CMD_LEN'(OP_RDCFG);
  wire rd_valid = cmd_done && (is_temp || is_cfg);
  wire rd_last  = is_temp ? (dpos == DPW'(TMP_LEN - 1)) : (dpos == DPW'(CFG_LEN - 1));
  wire bit_hi   = wdata == D_HIGH;

  logic [CMD_LEN-1:0] cmd_nxt;
  always_comb begin
    cmd_nxt = cmd;
    if (bit_hi) cmd_nxt[cmd_pos[CIW-1:0]] = 1'b1;
  end

  for (genvar g = 0; g < NSENS; g++) begin : g_sens
    logic [TMP_LEN-1:0] tsh;
    logic [CFG_LEN-1:0] csh;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        temp_r[g] <= TMP_LEN'(TEMP_INIT);
        cfg_r[g]  <= CFG_LEN'(CFG_INIT);
      end
    end
    assign tsh = temp_r[g] >> dpos;
    assign csh = cfg_r[g] >> dpos;
    assign sel_bits[g] = is_temp ? tsh[0] : csh[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_low <= 1'b0;
      cmd     <= '0;
      cmd_pos <= '0;
      dword   <= '0;
      dpos    <= '0;
      rdata   <= '0;
      unk_cmd <= 1'b0;
    end else if (wr_ctl) begin
      if (wdata == C_RST) begin
        cmd <= '0; cmd_pos <= '0; dword <= '0; dpos <= '0;
      end else if (wdata == C_CLKLO) begin
        clk_low <= 1'b1;
      end else if (wdata == C_CLKHI) begin
        clk_low <= 1'b0;
      end
    end else if (wr_dat) begin
      if (wdata == D_ENRD) begin
        dpos <= '0;
      end else if (clk_low) begin
        if (!cmd_done) begin
          if (cmd_pos == CPW'(CMD_LEN - 1) && cmd_nxt == CMD_LEN'(OP_CONV)) begin
            cmd <= '0; cmd_pos <= '0; dword <= '0; dpos <= '0;
          end else begin
            cmd     <= cmd_nxt;
            cmd_pos <= cmd_pos + 1'b1;
          end
        end else begin
          if (bit_hi && dpos < DPW'(DWORD_W)) dword[dpos[DIW-1:0]] <= 1'b1;
          if (dpos != '1) dpos <= dpos + 1'b1;
        end
      end
    end else if (rd_dat) begin
      if (rd_valid) begin
        rdata <= sel_bits;
        if (rd_last) begin
          cmd <= '0; cmd_pos <= '0; dword <= '0; dpos <= '0;
        end else begin
          dpos <= dpos + 1'b1;
        end
      end else begin
        rdata   <= '0;
        unk_cmd <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/quad_thermo_if_chk.sv
module quad_thermo_if_chk #(
  parameter int NSENS   = 4,
  parameter int CMD_LEN = 8,
  parameter int DWORD_W = 16,
  parameter logic [7:0] C_RST  = 8'h01,
  parameter logic [7:0] D_ENRD = 8'h80
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic [1:0]                     addr,
  input logic [7:0]                     wdata,
  input logic [NSENS-1:0]               rdata,
  input logic                           unk_cmd,
  input logic                           clk_low,
  input logic [$clog2(CMD_LEN+1)-1:0]   cmd_pos,
  input logic [$clog2(DWORD_W+1)-1:0]   dpos,
  input logic [DWORD_W-1:0]             dword,
  input logic                           rd_valid
);

  wire dw = wr_en && addr == 2'd1;
  wire cw = wr_en && addr == 2'd0;
  wire dr = rd_en && !wr_en && addr == 2'd2;

  AST_CMDPOS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pos <= ($clog2(CMD_LEN+1))'(CMD_LEN)); // R4
  AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dw && wdata != D_ENRD && !clk_low |=> $stable(cmd_pos) && $stable(dpos)); // R3
  AST_ENRD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    dw && wdata == D_ENRD |=> dpos == '0 && $stable(cmd_pos)); // R8
  AST_CTL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cw && wdata == C_RST |=> cmd_pos == '0 && dpos == '0 && dword == '0); // R9
  AST_UNK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unk_cmd |=> unk_cmd); // R10
  AST_BAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dr && !rd_valid |=> rdata == '0 && unk_cmd); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dr |=> $stable(rdata)); // R11

endmodule

bind quad_thermo_if quad_thermo_if_chk #(
  .NSENS(NSENS), .CMD_LEN(CMD_LEN), .DWORD_W(DWORD_W), .C_RST(C_RST), .D_ENRD(D_ENRD)
) u_chk (.*);

// File: tb/quad_thermo_if_bench.sv
module quad_thermo_if_bench;
  localparam int CLK_P = 10;
  localparam int NSTEP = 59;
  localparam logic [2:0] K_CTL = 3'd0, K_CMD = 3'd1, K_DW = 3'd2, K_RD = 3'd3, K_HOLD = 3'd4;

  // {kind, arg, zero code, expected rdata, expected unk_cmd, requirement}
  localparam logic [31:0] TBL [NSTEP] = '{
    {K_CTL, 8'h01, 8'h00, 4'h0, 1'b0, 8'd2},
    {K_CTL, 8'h02, 8'h00, 4'h0, 1'b0, 8'd2},
    {K_CMD, 8'hAA, 8'h00, 4'h0, 1'b0, 8'd5},   // R5 temperature 44 LSB first
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd5},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd5},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b0, 8'd5},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b0, 8'd5},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd5},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b0, 8'd5},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd5},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd5},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd5},
    {K_CMD, 8'hAC, 8'h05, 4'h0, 1'b0, 8'd4},   // R4 zero bits sent as 0x05
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd6},   // R6 config 0x02
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b0, 8'd6},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd6},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd6},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd6},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd6},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd6},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b0, 8'd6},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd10},  // R10 first unknown read after auto-reset
    {K_HOLD,8'h00, 8'h00, 4'h0, 1'b1, 8'd10},
    {K_CMD, 8'hAA, 8'h00, 4'h0, 1'b1, 8'd9},   // R9 abort mid transfer
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd9},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd9},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b1, 8'd9},
    {K_CTL, 8'h01, 8'h00, 4'h0, 1'b1, 8'd9},
    {K_HOLD,8'h00, 8'h00, 4'hF, 1'b1, 8'd11},  // R11 rdata held across writes
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd9},
    {K_CMD, 8'hEE, 8'h00, 4'h0, 1'b1, 8'd7},   // R7 start conversion
    {K_CMD, 8'hAC, 8'h00, 4'h0, 1'b1, 8'd7},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd7},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b1, 8'd7},
    {K_CTL, 8'h01, 8'h00, 4'h0, 1'b1, 8'd3},   // R3 clock high gates writes
    {K_CTL, 8'h03, 8'h00, 4'h0, 1'b1, 8'd3},
    {K_CMD, 8'hAA, 8'h00, 4'h0, 1'b1, 8'd3},
    {K_CTL, 8'h02, 8'h00, 4'h0, 1'b1, 8'd3},
    {K_CMD, 8'hAC, 8'h00, 4'h0, 1'b1, 8'd3},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd3},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b1, 8'd3},
    {K_CTL, 8'h01, 8'h00, 4'h0, 1'b1, 8'd8},   // R8 enable-read restarts
    {K_CMD, 8'hAA, 8'h00, 4'h0, 1'b1, 8'd8},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd8},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd8},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b1, 8'd8},
    {K_CTL, 8'h03, 8'h00, 4'h0, 1'b1, 8'd8},
    {K_DW,  8'h80, 8'h00, 4'h0, 1'b1, 8'd8},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd8},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd8},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b1, 8'd8},
    {K_CTL, 8'h02, 8'h00, 4'h0, 1'b1, 8'd12},  // R12 data writes keep command
    {K_DW,  8'h01, 8'h00, 4'h0, 1'b1, 8'd12},
    {K_DW,  8'h01, 8'h00, 4'h0, 1'b1, 8'd12},
    {K_DW,  8'h01, 8'h00, 4'h0, 1'b1, 8'd12},
    {K_DW,  8'h80, 8'h00, 4'h0, 1'b1, 8'd12},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd12},
    {K_RD,  8'h00, 8'h00, 4'h0, 1'b1, 8'd12},
    {K_RD,  8'h00, 8'h00, 4'hF, 1'b1, 8'd12}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] rdata;
  logic unk_cmd;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  quad_thermo_if u_quad_thermo_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .unk_cmd(unk_cmd)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd();
    addr = 2'd2; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c, input logic [7:0] zc);
    for (int i = 0; i < 8; i++) bus_wr(2'd1, c[i] ? 8'h01 : zc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 4'h0);
    check("R1 unk_cmd after reset", {3'b0, unk_cmd}, 4'h0);

    for (int s = 0; s < NSTEP; s++) begin
      logic [31:0] t;
      t = TBL[s];
      case (t[31:29])
        K_CTL: bus_wr(2'd0, t[28:21]);
        K_CMD: send_cmd(t[28:21], t[20:13]);
        K_DW:  bus_wr(2'd1, t[28:21]);
        default: begin
          if (t[31:29] == K_RD) bus_rd();
          check($sformatf("R%0d step %0d rdata", t[7:0], s), rdata, t[12:9]);
          check($sformatf("R%0d step %0d unk_cmd", t[7:0], s), {3'b0, unk_cmd}, {3'b0, t[8]});
        end
      endcase
    end

    // R1: reset again clears flags and the clock-low flag
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after second reset", rdata, 4'h0);
    check("R1 unk_cmd after second reset", {3'b0, unk_cmd}, 4'h0);
    send_cmd(8'hAC, 8'h00);
    bus_rd();
    check("R1 command ignored without clock low", {3'b0, unk_cmd}, 4'h1);
    // R2: unused address 3 leaves rdata alone
    bus_wr(2'd3, 8'h02);
    check("R2 unmapped write", rdata, 4'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule